// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking in-memory translation tables. For one translate request it reads the partition entry, then the process entry, then a radix tree of page directories. Every directory level sets the index width of the next level, so the depth of the tree depends on the data in memory. Each table read is an aligned 8-byte load on a single-outstanding read port. The result is a real address or a fault flag, reported with a one-cycle done pulse.

When relocation is off for the kind of access requested, the block returns the effective address unchanged and reads nothing. Before any read, the effective partition ID and process ID are chosen from the hypervisor and problem-state bits and the top two address bits (the quadrant). The block holds one translation at a time. While busy, it ignores new requests.

Top module: `radix_walker`

## Requirements
- R1: A fetch with `msr_ir`=0, or a load/store with `msr_dr`=0, gives done one cycle after acceptance. `real_addr` then equals `req_addr`, `fault`=0, and no memory read is issued.
- R2: The first read is at `{ptcr[59:12],12'h0}` + LPID*16 + 8. The effective LPID is 0 when `msr_hv`=1; otherwise it is `lpid_reg`.
- R3: The second read is at `{E[59:12],12'h0}` + PID*16, where E is the partition doubleword returned by the first read.
- R4: The effective PID is chosen from the quadrant (`req_addr[63:62]`).
  - With `msr_hv`=1 and `msr_pr`=0: quadrants 11 and 10 give PID 0, and the other quadrants use `pid_reg`.
  - In every other mode: quadrant 11 gives PID 0, quadrant 00 uses `pid_reg`, and quadrants 01 and 10 fault with no read issued.
- R5: From the process entry P:
  - useful bits = `{P[62:61],P[7:5]}` + 31;
  - root base = `{P[59:8],8'h0}`;
  - root width = `P[4:0]`.
  A level with base B, width W and useful count U reads B + ((addr >> (U-W)) & (2^W-1))*8.
- R6: In a directory entry D, bit 63 is valid and bit 62 is leaf. A valid non-leaf D continues the walk with base `{D[59:8],8'h0}`, width `D[4:0]`, and useful count U-W.
- R7: A valid leaf D with remaining useful count U-W = N gives `real_addr` = ((D & 0x01ffffffffff_f000) & ~(2^N-1)) | (addr & (2^N-1)).
- R8: Any of the following ends the walk with `fault`=1 and `real_addr`=0:
  - an entry with bit 63 clear;
  - a width below 5;
  - a width larger than the remaining useful count.
- R9: At most 5 directory entries are read. A valid non-leaf fifth entry faults, while a leaf fifth entry translates normally.
- R10: Memory requests are 8-byte aligned. A request holds its address until `mem_req_ready`. Only one read is outstanding at a time.
- R11: `busy` is high during a walk, and `req_valid` is ignored while it is high. Each translation yields exactly one single-cycle `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translate request strobe |
| req_addr | input | 64 | Effective address |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = load/store |
| msr_hv | input | 1 | Hypervisor state |
| msr_pr | input | 1 | Problem (user) state |
| msr_ir | input | 1 | Instruction relocation on |
| msr_dr | input | 1 | Data relocation on |
| ptcr | input | 64 | Partition table control word |
| lpid_reg | input | 32 | Logical partition ID |
| pid_reg | input | 32 | Process ID |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation failed |
| real_addr | output | 64 | Translated address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
The bench runs walks of one, three and five directory levels with different widths per level. A design that reduced the useful-bit count wrongly or used a fixed width would read the wrong entry addresses, and the bench compares every request address in order. Quadrant decoding is checked in hypervisor-kernel, hypervisor-user and guest modes. A wrong PID choice shows up as a wrong process-table read, or as a missing fault where a quadrant is illegal. The fault paths are also covered: an invalid entry, a width too small, a width larger than the remaining bits, and the five-level boundary, both as a leaf and as a non-leaf. An off-by-one depth counter would fault on the legal five-level leaf or keep reading past the limit. Request pokes during a walk would appear as extra done pulses or extra reads if the busy gate leaked.

// File: rtl/rw_pkg.sv
package rw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PART,
    ST_PROC,
    ST_DIR
  } walk_st_e;

  // real page field of a leaf entry
  localparam logic [63:0] PAGE_FIELD_MASK = 64'h01ff_ffff_ffff_f000;

  // table base held in bits 59:12, 4 KiB aligned
  function automatic logic [63:0] tbl_base(input logic [63:0] w);
    return {4'b0, w[59:12], 12'h000};
  endfunction

  // directory base held in bits 59:8, 256-byte aligned
  function automatic logic [63:0] dir_base(input logic [63:0] w);
    return {4'b0, w[59:8], 8'h00};
  endfunction

endpackage

// File: rtl/rw_ctx_select.sv
module rw_ctx_select #(
  parameter int ID_W = 32
) (
  input  logic            hv,
  input  logic            pr,
  input  logic [1:0]      quad,
  input  logic [ID_W-1:0] lpid_reg,
  input  logic [ID_W-1:0] pid_reg,
  output logic [ID_W-1:0] eff_lpid,
  output logic [ID_W-1:0] eff_pid,
  output logic            bad_quad
);

  always_comb begin
    eff_lpid = hv ? '0 : lpid_reg;
    bad_quad = 1'b0;
    eff_pid  = pid_reg;
    if (hv && !pr) begin
      // upper two quadrants map to the kernel context
      if (quad[1]) eff_pid = '0;
    end else begin
      unique case (quad)
        2'b11:   eff_pid = '0;
        2'b00:   eff_pid = pid_reg;
        default: begin
          eff_pid  = '0;
          bad_quad = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/rw_index_gen.sv
module rw_index_gen #(
  parameter int UW        = 7,
  parameter int MIN_WIDTH = 5
) (
  input  logic [63:0]   va,
  input  logic [63:0]   base,
  input  logic [4:0]    width,
  input  logic [UW-1:0] useful,
  output logic [63:0]   entry_addr,
  output logic          width_bad
);

  logic [UW-1:0] shift;
  logic [63:0]   idx;

  always_comb begin
    width_bad  = (int'(width) < MIN_WIDTH) || (UW'(width) > useful);
    shift      = useful - UW'(width);
    idx        = (va >> shift) & ((64'd1 << width) - 64'd1);
    entry_addr = base + (idx << 3);
  end

endmodule

// File: rtl/rw_leaf_merge.sv
module rw_leaf_merge
  import rw_pkg::*;
#(
  parameter int UW = 7
) (
  input  logic [63:0]   entry,
  input  logic [63:0]   va,
  input  logic [UW-1:0] remain,
  output logic [63:0]   real_out
);

  logic [63:0] pmask;

  always_comb begin
    pmask    = (64'd1 << remain) - 64'd1;
    real_out = ((entry & PAGE_FIELD_MASK) & ~pmask) | (va & pmask);
  end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int ID_W        = 32,
  parameter int MAX_LEVELS  = 5,
  parameter int MIN_WIDTH   = 5,
  parameter int BASE_USEFUL = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [63:0]     req_addr,
  input  logic            req_is_fetch,
  input  logic            msr_hv,
  input  logic            msr_pr,
  input  logic            msr_ir,
  input  logic            msr_dr,
  input  logic [63:0]     ptcr,
  input  logic [ID_W-1:0] lpid_reg,
  input  logic [ID_W-1:0] pid_reg,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [63:0]     real_addr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [63:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data
);

  localparam int UW = $clog2(65);
  localparam int LW = $clog2(MAX_LEVELS + 1);
  localparam logic [LW-1:0] LAST_LVL = LW'(MAX_LEVELS - 1);

  walk_st_e        st_q;
  logic [63:0]     va_q;
  logic [ID_W-1:0] pid_q;
  logic [63:0]     base_q;
  logic [4:0]      width_q;
  logic [UW-1:0]   useful_q;
  logic [LW-1:0]   lvl_q;
  logic            wait_q;

  logic [ID_W-1:0] eff_lpid, eff_pid;
  logic            bad_quad;
  logic            real_mode;
  logic            accept;
  logic            rsp_take;
  logic [UW-1:0]   remain, tree_sz, nx_useful;
  logic [63:0]     nx_base, ent_addr, leaf_ra;
  logic [4:0]      nx_width;
  logic            w_bad;

  rw_ctx_select #(.ID_W(ID_W)) u_ctx (
    .hv       (msr_hv),
    .pr       (msr_pr),
    .quad     (req_addr[63:62]),
    .lpid_reg (lpid_reg),
    .pid_reg  (pid_reg),
    .eff_lpid (eff_lpid),
    .eff_pid  (eff_pid),
    .bad_quad (bad_quad)
  );

  always_comb begin
    real_mode = req_is_fetch ? !msr_ir : !msr_dr;
    accept    = (st_q == ST_IDLE) && req_valid;
    rsp_take  = wait_q && mem_rsp_valid;
    remain    = useful_q - UW'(width_q);
    tree_sz   = UW'({mem_rsp_data[62:61], mem_rsp_data[7:5]}) + UW'(BASE_USEFUL);
    nx_useful = (st_q == ST_PROC) ? tree_sz : remain;
    nx_base   = dir_base(mem_rsp_data);
    nx_width  = mem_rsp_data[4:0];
  end

  rw_index_gen #(.UW(UW), .MIN_WIDTH(MIN_WIDTH)) u_idx (
    .va         (va_q),
    .base       (nx_base),
    .width      (nx_width),
    .useful     (nx_useful),
    .entry_addr (ent_addr),
    .width_bad  (w_bad)
  );

  rw_leaf_merge #(.UW(UW)) u_leaf (
    .entry    (mem_rsp_data),
    .va       (va_q),
    .remain   (remain),
    .real_out (leaf_ra)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      va_q          <= '0;
      pid_q         <= '0;
      base_q        <= '0;
      width_q       <= '0;
      useful_q      <= '0;
      lvl_q         <= '0;
      wait_q        <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      fault         <= 1'b0;
      real_addr     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      done <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
        wait_q        <= 1'b1;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            va_q  <= req_addr;
            pid_q <= eff_pid;
            if (real_mode) begin
              done      <= 1'b1;
              fault     <= 1'b0;
              real_addr <= req_addr;
            end else if (bad_quad) begin
              done      <= 1'b1;
              fault     <= 1'b1;
              real_addr <= '0;
            end else begin
              busy          <= 1'b1;
              st_q          <= ST_PART;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= tbl_base(ptcr) + 64'({eff_lpid, 4'b1000});
            end
          end
        end
        ST_PART: begin
          if (rsp_take) begin
            wait_q        <= 1'b0;
            st_q          <= ST_PROC;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= tbl_base(mem_rsp_data) + 64'({pid_q, 4'b0000});
          end
        end
        ST_PROC: begin
          if (rsp_take) begin
            wait_q <= 1'b0;
            if (w_bad) begin
              st_q      <= ST_IDLE;
              busy      <= 1'b0;
              done      <= 1'b1;
              fault     <= 1'b1;
              real_addr <= '0;
            end else begin
              base_q        <= nx_base;
              width_q       <= nx_width;
              useful_q      <= nx_useful;
              lvl_q         <= '0;
              st_q          <= ST_DIR;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ent_addr;
            end
          end
        end
        ST_DIR: begin
          if (rsp_take) begin
            wait_q <= 1'b0;
            if (mem_rsp_data[63] && mem_rsp_data[62]) begin
              st_q      <= ST_IDLE;
              busy      <= 1'b0;
              done      <= 1'b1;
              fault     <= 1'b0;
              real_addr <= leaf_ra;
            end else if (!mem_rsp_data[63] || (lvl_q == LAST_LVL) || w_bad) begin
              st_q      <= ST_IDLE;
              busy      <= 1'b0;
              done      <= 1'b1;
              fault     <= 1'b1;
              real_addr <= '0;
            end else begin
              base_q        <= nx_base;
              width_q       <= nx_width;
              useful_q      <= nx_useful;
              lvl_q         <= lvl_q + 1'b1;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ent_addr;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (accept && real_mode) |=> (done && !fault && real_addr == $past(req_addr))); // R1
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (real_addr == 64'd0)); // R8
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(lvl_q) < MAX_LEVELS)); // R9
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    wait_q |-> !mem_req_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid); // R11

endmodule

// File: tb/test_radix_walker.sv
module test_radix_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_is_fetch = 1'b0;
  logic        msr_hv = 1'b0, msr_pr = 1'b0, msr_ir = 1'b0, msr_dr = 1'b0;
  logic [63:0] ptcr = 64'h0000_0000_0001_0004;
  logic [31:0] lpid_reg = 32'd3;
  logic [31:0] pid_reg = 32'd2;
  logic        busy, done, fault;
  logic [63:0] real_addr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  radix_walker i_radix_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_fetch(req_is_fetch), .msr_hv(msr_hv), .msr_pr(msr_pr),
    .msr_ir(msr_ir), .msr_dr(msr_dr), .ptcr(ptcr), .lpid_reg(lpid_reg),
    .pid_reg(pid_reg), .busy(busy), .done(done), .fault(fault),
    .real_addr(real_addr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  typedef struct {
    logic [63:0] ra;
    logic        flt;
    string       tag;
  } exp_t;

  int          n_cmp = 0;
  int          n_bad = 0;
  exp_t        exp_q[$];
  logic [63:0] rd_q[$];
  string       rd_tag_q[$];
  logic [63:0] mem [logic [63:0]];

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(input logic [63:0] a, input string tag);
    rd_q.push_back(a);
    rd_tag_q.push_back(tag);
  endtask

  // memory responder: stalls ready one cycle in three, answers two cycles later
  initial begin
    int          stall = 0;
    int          pend = 0;
    logic [63:0] pend_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
        end
      end
      stall++;
      mem_req_ready = (stall % 3) != 0;
      if (!rst && mem_req_valid && mem_req_ready) begin
        if (pend != 0) check(1'b0, "R10 read issued while one outstanding", mem_req_addr, 64'd0);
        if (rd_q.size() == 0) begin
          check(1'b0, "R10 unexpected read", mem_req_addr, 64'd0);
        end else begin
          logic [63:0] ea;
          string       et;
          ea = rd_q.pop_front();
          et = rd_tag_q.pop_front();
          check(mem_req_addr == ea, et, mem_req_addr, ea);
        end
        pend_addr = mem_req_addr;
        pend      = 2;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected done", real_addr, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(real_addr == e.ra, e.tag, real_addr, e.ra);
          check(fault == e.flt, {e.tag, " fault flag"}, 64'(fault), 64'(e.flt));
        end
      end
    end
  end

  task automatic run(input string tag, input logic [63:0] va, input bit fetch,
                     input bit hv, input bit pr, input bit ir, input bit dr,
                     input logic [63:0] ra, input bit flt, input bit poke);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    msr_hv = hv; msr_pr = pr; msr_ir = ir; msr_dr = dr;
    req_addr = va; req_is_fetch = fetch; req_valid = 1'b1;
    e.ra = ra; e.flt = flt; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      check(busy == 1'b1, "R11 busy during walk", 64'(busy), 64'd1);
      req_addr = 64'h0000_0000_dead_beef; msr_dr = 1'b0; req_is_fetch = 1'b0;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rd_q.size() == 0, {tag, " R10 all expected reads issued"}, 64'(rd_q.size()), 64'd0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mem[64'h10008]  = 64'hC000_0000_0020_000B;
    mem[64'h10038]  = 64'h0000_0000_0030_0000;
    mem[64'h200000] = 64'h4000_0000_0004_00AD;
    mem[64'h200020] = 64'h0000_0000_0008_0005;
    mem[64'h300000] = 64'h4000_0000_000A_00A5;
    mem[64'h300020] = 64'h0000_0000_0009_0004;
    mem[64'h40028]  = 64'h8000_0000_0006_0009;
    mem[64'h60018]  = 64'h8000_0000_0007_0009;
    mem[64'h70038]  = 64'hC000_0ABC_DE7F_F187;
    mem[64'h80010]  = 64'hC000_0000_5C00_0187;
    mem[64'h80018]  = 64'h8000_0000_0008_101B;
    mem[64'hA0000]  = 64'h8000_0000_000A_1005;
    mem[64'hA1000]  = 64'h8000_0000_000A_2005;
    mem[64'hA2000]  = 64'h8000_0000_000A_3005;
    mem[64'hA3000]  = 64'h8000_0000_000A_4005;
    mem[64'hA4000]  = 64'h8000_0000_000A_5005;
    mem[64'hA4008]  = 64'hC000_00F0_0000_0000;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_req_valid, "R11 reset state idle",
          {61'd0, busy, done, mem_req_valid}, 64'd0);

    // R1: relocation off
    run("R1 fetch with relocation off", 64'h1234_5678_9ABC_DEF0, 1, 1, 0, 0, 1,
        64'h1234_5678_9ABC_DEF0, 0, 0);
    run("R1 data with relocation off", 64'hFEDC_BA98_7654_3210, 0, 1, 0, 1, 0,
        64'hFEDC_BA98_7654_3210, 0, 0);

    // three-level walk, hypervisor kernel, quadrant 11, with busy pokes
    exp_rd(64'h10008,  "R2 partition read hv");
    exp_rd(64'h200000, "R3 process read pid0");
    exp_rd(64'h40028,  "R5 root entry read");
    exp_rd(64'h60018,  "R6 second level read");
    exp_rd(64'h70038,  "R6 third level read");
    run("R7 three-level leaf", 64'hC100_0280_C0E1_2345, 0, 1, 0, 1, 1,
        64'h0000_0ABC_DE61_2345, 0, 1);

    // quadrant 10 in hypervisor kernel, fetch governed by ir
    exp_rd(64'h10008,  "R2 partition read q10");
    exp_rd(64'h200000, "R4 quadrant 10 kernel uses pid 0");
    exp_rd(64'h40028,  "R5 root entry read q10");
    exp_rd(64'h60018,  "R6 second level read q10");
    exp_rd(64'h70038,  "R6 third level read q10");
    run("R4 hv kernel quadrant 10", 64'h8100_0280_C0E1_2345, 1, 1, 0, 1, 0,
        64'h0000_0ABC_DE61_2345, 0, 0);

    // quadrant 00 in hypervisor kernel uses pid register, one-level leaf
    exp_rd(64'h10008,  "R2 partition read q00");
    exp_rd(64'h200020, "R4 quadrant 00 kernel uses pid reg");
    exp_rd(64'h80010,  "R5 root read small tree");
    run("R7 root-level leaf", 64'h0000_0055_0923_4567, 0, 1, 0, 1, 1,
        64'h0000_0000_5D23_4567, 0, 0);

    // illegal quadrants
    run("R4 guest quadrant 01 fault", 64'h4000_0000_0000_1000, 0, 0, 1, 1, 1,
        64'd0, 1, 0);
    run("R4 hv user quadrant 10 fault", 64'h8000_0000_0000_1000, 0, 1, 1, 1, 1,
        64'd0, 1, 0);

    // hypervisor user, quadrant 00
    exp_rd(64'h10008,  "R2 partition read hv user lpid 0");
    exp_rd(64'h200020, "R4 hv user quadrant 00 pid reg");
    exp_rd(64'h80010,  "R5 root read hv user");
    run("R4 hv user translate", 64'h0000_0055_0923_4567, 0, 1, 1, 1, 1,
        64'h0000_0000_5D23_4567, 0, 0);

    // guest: root width too small
    exp_rd(64'h10038,  "R2 guest partition read lpid 3");
    exp_rd(64'h300020, "R3 guest process read pid reg");
    run("R8 root width below 5", 64'h0000_0000_0000_1000, 0, 0, 0, 1, 1,
        64'd0, 1, 0);

    // depth limit
    exp_rd(64'h10038,  "R2 guest partition read depth");
    exp_rd(64'h300000, "R3 guest process read pid0");
    exp_rd(64'hA0000,  "R9 level 1 read");
    exp_rd(64'hA1000,  "R9 level 2 read");
    exp_rd(64'hA2000,  "R9 level 3 read");
    exp_rd(64'hA3000,  "R9 level 4 read");
    exp_rd(64'hA4000,  "R9 level 5 read");
    run("R9 fifth level non-leaf fault", 64'hC000_0000_0000_0000, 0, 0, 0, 1, 1,
        64'd0, 1, 0);

    exp_rd(64'h10038,  "R2 guest partition read depth leaf");
    exp_rd(64'h300000, "R3 guest process read depth leaf");
    exp_rd(64'hA0000,  "R9 leaf walk level 1");
    exp_rd(64'hA1000,  "R9 leaf walk level 2");
    exp_rd(64'hA2000,  "R9 leaf walk level 3");
    exp_rd(64'hA3000,  "R9 leaf walk level 4");
    exp_rd(64'hA4008,  "R9 leaf walk level 5");
    run("R9 fifth level leaf", 64'hC000_0000_0812_3456, 0, 0, 0, 1, 1,
        64'h0000_00F0_0012_3456, 0, 0);

    // invalid entry
    exp_rd(64'h10038,  "R2 guest partition read invalid");
    exp_rd(64'h300000, "R3 guest process read invalid");
    exp_rd(64'hA0008,  "R8 root read of invalid entry");
    run("R8 invalid entry fault", 64'hC000_8000_0000_0000, 0, 0, 0, 1, 1,
        64'd0, 1, 0);

    // width exceeding remaining bits
    exp_rd(64'h10008,  "R2 partition read wide");
    exp_rd(64'h200020, "R3 process read wide");
    exp_rd(64'h80018,  "R8 root read wide width");
    run("R8 width above remaining fault", 64'h0000_0000_0C00_0000, 0, 1, 0, 1, 1,
        64'd0, 1, 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule